// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside a SECDED checker that guards 64-bit memory words with 8 check bits. Each cycle the checker may report one event: a corrected (single-bit) error, an uncorrectable (multi-bit) error, or both at once. The block keeps a record of the earliest event only. The record holds the upper 19 bits of the failing byte address, the 8-bit syndrome, and one sticky flag for each error kind. After the first capture the record is frozen, and it accepts nothing new until software clears both flags in a single write.

Software sees the block as one 32-bit register with a combinational read path. Bit 31 disables scrubbing and is read/write. Bits 30:12 hold the captured address bits 31:13 and are read-only. Bits 11:4 hold the syndrome and are read-only. Bit 3 enables the bus-error output and bit 2 enables the NMI output; both are read/write. Bit 1 is the multi-bit flag and bit 0 is the single-bit flag; both are write-one-to-clear. The block drives two level outputs, an NMI request and a bus-error signal.

The block also raises a one-cycle scrub request for every corrected read while scrubbing is enabled. The event input carries only a valid strobe and has no ready signal. The block takes an event in every cycle, so it never applies back-pressure. The scrub request is likewise a bare pulse for the memory datapath to act on.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the register reads 32'h0000_0000, and nmi_req, bus_err and scrub_req are low.
- R2: Suppose both flags are clear and an event arrives (evt_valid=1 with evt_sbe or evt_mbe set). On the next cycle bits 30:12 hold evt_addr[31:13], bits 11:4 hold evt_syn, and bit 0 is set for a single-bit event or bit 1 for a multi-bit event.
- R3: When evt_sbe and evt_mbe are both set in the same event, only bit 1 (multi-bit) is set. The two flags are never set together.
- R4: While bit 0 or bit 1 is set, later events change neither the flags nor bits 30:4.
- R5: The flags clear only when a write has wr_data[1:0]=2'b11. Writing 2'b01, 2'b10 or 2'b00 leaves the flags as they are. An event that arrives in the same cycle as a clearing write is captured into the freshly cleared record.
- R6: Each write loads bits 31, 3 and 2 from wr_data. The values written to bits 30:4 are ignored.
- R7: nmi_req is high exactly when bit 0 and bit 2 are both set.
- R8: bus_err is high exactly when bit 1 and bit 3 are both set.
- R9: An event with evt_sbe=1 and evt_mbe=0, seen while bit 31 is 0, raises scrub_req for the next cycle only, with scrub_addr equal to that event's evt_addr. This happens whether or not the event is captured. No pulse follows when bit 31 is 1 or when evt_mbe is set.
- R10: A clear leaves bits 30:4 holding the old address and syndrome until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Checker reports an event this cycle |
| evt_sbe | input | 1 | Event is a corrected single-bit error |
| evt_mbe | input | 1 | Event is an uncorrectable multi-bit error |
| evt_addr | input | 32 | Byte address of the checked access |
| evt_syn | input | 8 | Syndrome from the checker |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Register read value |
| nmi_req | output | 1 | NMI request level |
| bus_err | output | 1 | Bus-error level |
| scrub_req | output | 1 | One-cycle writeback request for corrected data |
| scrub_addr | output | 32 | Address to scrub, valid with scrub_req |

## Verification
The assertions check several rules on every cycle: the frozen record never moves while a flag is set, the flags are never both set, and the two alarm levels always match their flag and enable. They also check that every corrected read while scrubbing is enabled is followed by exactly one scrub pulse, and that no pulse appears without such a cause. Other behaviour shows only in the bench's scenarios. These include:
- the first-error-wins order across a sequence of events;
- that a half clear (bits 1:0 = 01 or 10) leaves the flags alone;
- that the old address and syndrome survive a clear;
- that an event arriving in the same cycle as a clear is captured.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned SYN_W      = 8;
  localparam int unsigned KEEP_W     = 19;
  localparam int unsigned SBE_BIT    = 0;
  localparam int unsigned MBE_BIT    = 1;
  localparam int unsigned NMI_EN_BIT = 2;
  localparam int unsigned BERR_EN_BIT = 3;
  localparam int unsigned SCRUB_DIS_BIT = 31;

  typedef struct packed {
    logic [KEEP_W-1:0] addr_hi;
    logic [SYN_W-1:0]  syn;
    logic              mbe;
    logic              sbe;
  } err_rec_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             scrub_dis,
  output logic             berr_en,
  output logic             nmi_en,
  output logic             clr
);
  // both status bits must be written with one in the same access
  assign clr = wr_en & wr_data[SBE_BIT] & wr_data[MBE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scrub_dis <= 1'b0;
      berr_en   <= 1'b0;
      nmi_en    <= 1'b0;
    end else if (wr_en) begin
      scrub_dis <= wr_data[SCRUB_DIS_BIT];
      berr_en   <= wr_data[BERR_EN_BIT];
      nmi_en    <= wr_data[NMI_EN_BIT];
    end
  end
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
  import ecc_log_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              evt_valid,
  input  logic              evt_sbe,
  input  logic              evt_mbe,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [SYN_W-1:0]  evt_syn,
  output err_rec_t          rec
);
  localparam int unsigned HI_LSB = ADDR_W - KEEP_W;

  logic held;
  logic open_slot;
  logic take;

  assign held      = rec.sbe | rec.mbe;
  assign open_slot = ~held | clr;
  assign take      = open_slot & evt_valid & (evt_sbe | evt_mbe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec <= '0;
    end else begin
      if (clr) begin
        rec.sbe <= 1'b0;
        rec.mbe <= 1'b0;
      end
      if (take) begin
        rec.addr_hi <= evt_addr[ADDR_W-1:HI_LSB];
        rec.syn     <= evt_syn;
        rec.mbe     <= evt_mbe;
        rec.sbe     <= ~evt_mbe;   // uncorrectable wins a tie
      end
    end
  end
endmodule

// File: rtl/ecc_log_scrub.sv
module ecc_log_scrub #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scrub_dis,
  input  logic              evt_valid,
  input  logic              evt_sbe,
  input  logic              evt_mbe,
  input  logic [ADDR_W-1:0] evt_addr,
  output logic              scrub_req,
  output logic [ADDR_W-1:0] scrub_addr
);
  logic fire;
  assign fire = evt_valid & evt_sbe & ~evt_mbe & ~scrub_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scrub_req  <= 1'b0;
      scrub_addr <= '0;
    end else begin
      scrub_req <= fire;
      if (fire) scrub_addr <= evt_addr;
    end
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic              evt_sbe,
  input  logic              evt_mbe,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [7:0]        evt_syn,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              nmi_req,
  output logic              bus_err,
  output logic              scrub_req,
  output logic [ADDR_W-1:0] scrub_addr
);
  logic     scrub_dis, berr_en, nmi_en, clr;
  err_rec_t rec;

  ecc_log_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .scrub_dis(scrub_dis), .berr_en(berr_en), .nmi_en(nmi_en), .clr(clr)
  );

  ecc_log_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt_valid(evt_valid),
    .evt_sbe(evt_sbe), .evt_mbe(evt_mbe), .evt_addr(evt_addr),
    .evt_syn(evt_syn), .rec(rec)
  );

  ecc_log_scrub #(.ADDR_W(ADDR_W)) u_scrub (
    .clk(clk), .rst_n(rst_n), .scrub_dis(scrub_dis), .evt_valid(evt_valid),
    .evt_sbe(evt_sbe), .evt_mbe(evt_mbe), .evt_addr(evt_addr),
    .scrub_req(scrub_req), .scrub_addr(scrub_addr)
  );

  assign rd_data = {scrub_dis, rec.addr_hi, rec.syn, berr_en, nmi_en, rec.mbe, rec.sbe};
  assign nmi_req = rec.sbe & nmi_en;
  assign bus_err = rec.mbe & berr_en;
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_sbe,
  input logic              evt_mbe,
  input logic [ADDR_W-1:0] evt_addr,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              nmi_req,
  input logic              bus_err,
  input logic              scrub_req,
  input logic [ADDR_W-1:0] scrub_addr
);
  logic wr_clear;
  assign wr_clear = wr_en & (wr_data[1:0] == 2'b11);

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[1:0] != 2'b00) && !wr_clear) |=>
      (rd_data[30:0] & 31'h7FFF_FFF3) == ($past(rd_data[30:0]) & 31'h7FFF_FFF3));

  p_one_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] != 2'b11);

  p_mbe_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[1:0] == 2'b00) && evt_valid && evt_mbe) |=> rd_data[1]);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clear && !evt_valid) |=> rd_data[1:0] == 2'b00);

  p_nmi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == (rd_data[0] & rd_data[2]));

  p_berr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err == (rd_data[1] & rd_data[3]));

  p_scrub_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_sbe && !evt_mbe && !rd_data[31]) |=>
      (scrub_req && scrub_addr == $past(evt_addr)));

  p_no_stray_scrub_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && evt_sbe && !evt_mbe && !rd_data[31]) |=> !scrub_req);
endmodule

bind ecc_err_log ecc_err_log_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_sbe(evt_sbe),
  .evt_mbe(evt_mbe), .evt_addr(evt_addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .nmi_req(nmi_req), .bus_err(bus_err),
  .scrub_req(scrub_req), .scrub_addr(scrub_addr)
);

// File: tb/sim_ecc_err_log.sv
`timescale 1ns/1ps
module sim_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0, evt_sbe = 1'b0, evt_mbe = 1'b0;
  logic [31:0] evt_addr = '0;
  logic [7:0]  evt_syn = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        nmi_req, bus_err, scrub_req;
  logic [31:0] scrub_addr;

  always #2.5 clk = ~clk;

  ecc_err_log u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_sbe(evt_sbe),
    .evt_mbe(evt_mbe), .evt_addr(evt_addr), .evt_syn(evt_syn),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .nmi_req(nmi_req),
    .bus_err(bus_err), .scrub_req(scrub_req), .scrub_addr(scrub_addr)
  );

  int    total = 0, bad = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural reference state
  logic        m_dis = 0, m_be = 0, m_nmi = 0, m_fs = 0, m_fm = 0, m_scr = 0;
  logic [18:0] m_ahi = '0;
  logic [7:0]  m_syn = '0;
  logic [31:0] m_saddr = '0;
  logic        m_clr, m_free;

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dis = 0; m_be = 0; m_nmi = 0; m_fs = 0; m_fm = 0; m_scr = 0;
      m_ahi = '0; m_syn = '0; m_saddr = '0;
    end else begin
      m_clr  = wr_en && (wr_data[1:0] == 2'b11);
      m_free = !(m_fs || m_fm) || m_clr;
      m_scr  = evt_valid && evt_sbe && !evt_mbe && !m_dis;
      if (m_scr) m_saddr = evt_addr;
      if (m_clr) begin m_fs = 0; m_fm = 0; end
      if (m_free && evt_valid && (evt_sbe || evt_mbe)) begin
        m_ahi = 19'(evt_addr >> 13);
        m_syn = evt_syn;
        m_fm  = evt_mbe;
        m_fs  = !evt_mbe;
      end
      if (wr_en) begin
        m_dis = wr_data[31]; m_be = wr_data[3]; m_nmi = wr_data[2];
      end
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] exp;
      exp = {m_dis, m_ahi, m_syn, m_be, m_nmi, m_fm, m_fs};
      chk(rd_data === exp, tag, rd_data, exp);
      chk(nmi_req === (m_fs & m_nmi), "R7", {31'b0, nmi_req}, {31'b0, m_fs & m_nmi});
      chk(bus_err === (m_fm & m_be), "R8", {31'b0, bus_err}, {31'b0, m_fm & m_be});
      chk(scrub_req === m_scr, "R9", {31'b0, scrub_req}, {31'b0, m_scr});
      if (m_scr) chk(scrub_addr === m_saddr, "R9", scrub_addr, m_saddr);
    end
  end

  task automatic ev(input bit s, input bit m, input logic [31:0] a, input logic [7:0] y);
    @(negedge clk);
    evt_valid = 1; evt_sbe = s; evt_mbe = m; evt_addr = a; evt_syn = y;
    @(negedge clk);
    evt_valid = 0; evt_sbe = 0; evt_mbe = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk(rd_data === 32'h0, "R1", rd_data, 32'h0);
    chk({nmi_req, bus_err, scrub_req} === 3'b000, "R1", {29'b0, nmi_req, bus_err, scrub_req}, 32'h0);

    // R6: control bits load, read-only fields ignore writes
    tag = "R6";
    wr(32'hFFFF_FFFF);
    chk(rd_data === 32'h8000_000C, "R6", rd_data, 32'h8000_000C);
    wr(32'h0000_0004);
    chk(rd_data === 32'h0000_0004, "R6", rd_data, 32'h0000_0004);

    // R2 first corrected error captured, R7 NMI, R9 scrub
    tag = "R2";
    ev(1, 0, 32'hDEAD_BEEF, 8'h5A);
    chk(rd_data === 32'h6F56_D5A5, "R2", rd_data, 32'h6F56_D5A5);
    chk(nmi_req === 1'b1, "R7", {31'b0, nmi_req}, 32'h1);

    // R4 later events frozen out
    tag = "R4";
    ev(0, 1, 32'h1234_5678, 8'hC3);
    ev(1, 0, 32'h0000_2000, 8'h11);
    chk(rd_data === 32'h6F56_D5A5, "R4", rd_data, 32'h6F56_D5A5);

    // R5 half clears ignored
    tag = "R5";
    wr(32'h0000_0005);
    wr(32'h0000_0006);
    chk(rd_data[1:0] === 2'b01, "R5", rd_data, 32'h1);
    wr(32'h0000_0007);
    chk(rd_data[1:0] === 2'b00, "R5", rd_data, 32'h0);
    // R10 record retained after clear
    chk(rd_data[30:4] === 27'h6F56_D5A, "R10", {5'b0, rd_data[30:4]}, 32'h06F5_6D5A);

    // R3 simultaneous sbe+mbe, R8 bus error
    tag = "R3";
    wr(32'h0000_0008);
    ev(1, 1, 32'hFFFF_E000, 8'h81);
    chk(rd_data[1:0] === 2'b10, "R3", rd_data, 32'h2);
    chk(bus_err === 1'b1, "R8", {31'b0, bus_err}, 32'h1);

    // R5 clear with same-cycle event
    tag = "R5";
    @(negedge clk);
    wr_en = 1; wr_data = 32'h0000_0003;
    evt_valid = 1; evt_sbe = 1; evt_mbe = 0; evt_addr = 32'h0040_6000; evt_syn = 8'h3C;
    @(negedge clk);
    wr_en = 0; evt_valid = 0; evt_sbe = 0;
    chk(rd_data[1:0] === 2'b01, "R5", rd_data, 32'h1);

    // R9 scrub disabled, and mbe suppresses scrub
    tag = "R9";
    wr(32'h8000_0003);
    ev(1, 0, 32'h0000_4000, 8'h01);
    ev(0, 1, 32'h0000_8000, 8'h02);
    wr(32'h0000_0003);
    ev(1, 1, 32'h0000_C000, 8'h03);
    ev(1, 0, 32'h7FFF_FFFF, 8'hFF);
    ev(1, 0, 32'h0001_0000, 8'h04);

    // mixed stream
    tag = "R2";
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 3) wr(32'h0000_000F);
      else ev(i[0], i[1] & i[2], 32'h0100_0000 * i + 32'h2000 * i, 8'(i * 13));
    end
    repeat (2) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule